// File: doc/BRIEF.md
# Serial Offset Difference Calculator

This block works out (B − A) + K one bit per clock on 8-bit display samples. The zero level of a difference trace can then be placed anywhere on the screen. Operand A comes in first and is held in a shared shift register. B and the user offset K then arrive together, least significant bit first, and each result bit is written back into the same register as the A bits are consumed.

When the most significant result bit is formed, the block checks the two arithmetic flags. A borrow out of the subtraction or a carry out of the offset addition marks the value as off-screen and raises a blank flag. A sync pulse then drains the register in the opposite direction, most significant bit first, towards the display latch. The latch and its blank flag take the new value only if display-enable was high at that sync. Other traffic that passes through the shared register therefore never reaches the display.

The three request inputs are meant to be used one at a time. If they overlap, an unload in progress wins, then a calculation step, then an A load.

Top module: `serial_offset_diff`

## Requirements
- R1: Each `a_vld` cycle shifts `a_bit` into the register, least significant bit first. Eight such cycles hold operand A.
- R2: Each `calc_vld` cycle processes one bit position, least significant bit first. The eighth cycle completes a word, and the next cycle starts bit 0 of a new word. The word result equals (B − A + K) modulo 256.
- R3: The result replaces A in the same register. A register filled only by `a_vld` cycles unloads as A itself.
- R4: The borrow and carry state is treated as zero at bit 0 of every word, so flags from an earlier word have no effect.
- R5: The pending blank flag is 1 when B < A, or when ((B − A) mod 256) + K > 255. Otherwise it is 0.
- R6: When a `sync` is sampled, `ser_vld` is high for the next 8 cycles. During those cycles `ser_out` carries the register contents, bit 7 first.
- R7: If `dsp_en` was 1 at the sampled `sync`, `disp_q` and `blank_q` take the unloaded word and the pending blank flag at the 8th clock edge after that sync. If `dsp_en` was 0, both keep their previous values.
- R8: While reset is active, `disp_q`, `blank_q` and `ser_vld` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_vld | input | 1 | Shift one bit of A into the register |
| a_bit | input | 1 | Serial A bit |
| calc_vld | input | 1 | Process one bit position of B and K |
| b_bit | input | 1 | Serial B bit |
| k_bit | input | 1 | Serial offset K bit |
| sync | input | 1 | Start an MSB-first unload |
| dsp_en | input | 1 | Allow the display latch to be updated by this unload |
| ser_out | output | 1 | Serial unload data, MSB first |
| ser_vld | output | 1 | Unload in progress |
| disp_q | output | 8 | Display latch |
| blank_q | output | 1 | Blank flag held with the display latch |

## Verification
The operand sets cover four cases:
- a plain in-range difference;
- a borrow case, where B < A and the offset brings the value back into range;
- a carry case, where the offset pushes an in-range difference past 255;
- the limit values 0 and 255, including B = A with K = 255.

These separate a wrong subtraction direction from a missing flag and from a flag check placed on the wrong operation. A clean word right after a blanked one shows whether flags leak across words. Unloads with display-enable low, one after a real word and one after an A-only load, distinguish gating of the latch from reuse of the register contents.

// File: rtl/sod_pkg.sv
// Shared types and the one-bit serial arithmetic step.
// Assumes operands arrive least significant bit first.
package sod_pkg;
    typedef struct packed {
        logic r;    // result bit
        logic bw;   // borrow out of B - A
        logic c;    // carry out of (B - A) + K
    } sod_step_t;

    // Compute one bit position of (B - A) + K.
    function automatic sod_step_t sod_step(input logic a, input logic b,
                                           input logic k, input logic bw_in,
                                           input logic c_in);
        sod_step_t s;
        logic d;
        d    = b ^ a ^ bw_in;
        s.bw = (~b & a) | (~(b ^ a) & bw_in);
        s.r  = d ^ k ^ c_in;
        s.c  = (d & k) | (c_in & (d ^ k));
        return s;
    endfunction
endpackage

// File: rtl/sod_bit_alu.sv
// Serial subtract-then-add unit with its borrow and carry flip-flops.
// Assumes the caller marks bit 0 (first) and the most significant bit (last)
// of each word; the flags read as zero on the first bit of every word.
module sod_bit_alu (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic first,
    input  logic last,
    input  logic a_bit,
    input  logic b_bit,
    input  logic k_bit,
    output logic r_bit,
    output logic blank_pend
);
    import sod_pkg::*;

    logic      bw_q, c_q;
    logic      bw_in, c_in;
    sod_step_t res;

    // Select the incoming flags, forcing zero at the start of a word.
    always_comb begin
        bw_in = first ? 1'b0 : bw_q;
        c_in  = first ? 1'b0 : c_q;
        res   = sod_step(a_bit, b_bit, k_bit, bw_in, c_in);
        r_bit = res.r;
    end

    // Register the flags each step and capture the off-screen verdict at the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bw_q       <= 1'b0;
            c_q        <= 1'b0;
            blank_pend <= 1'b0;
        end else if (step) begin
            bw_q <= res.bw;
            c_q  <= res.c;
            if (last)
                blank_pend <= res.bw | res.c;
        end
    end

    // R4: on bit 0 the result bit depends only on the three operand bits.
    a_r4_first_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (step && first) |-> (r_bit == (a_bit ^ b_bit ^ k_bit)));
endmodule

// File: rtl/sod_shift_reg.sv
// Shared word register: right shift for loading and calculation, left shift for unload.
// Assumes at most one of the mode inputs is acted on per cycle; unload has top priority.
module sod_shift_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         load_bit,
    input  logic         calc,
    input  logic         calc_bit,
    input  logic         unload,
    output logic         lsb,
    output logic         msb
);
    logic [W-1:0] sr;

    // Shift according to the active mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr <= '0;
        else if (unload)
            sr <= {sr[W-2:0], 1'b0};
        else if (calc)
            sr <= {calc_bit, sr[W-1:1]};
        else if (load)
            sr <= {load_bit, sr[W-1:1]};
    end

    assign lsb = sr[0];
    assign msb = sr[W-1];

    // R1: a loaded bit appears at the top end on the next cycle.
    a_r1_load_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !calc && !unload) |=> (msb == $past(load_bit)));
endmodule

// File: rtl/serial_offset_diff.sv
// Top level: sequences bit positions, unload and the display latch.
// Assumes the a_vld, calc_vld and sync requests do not overlap in normal use.
module serial_offset_diff #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         a_vld,
    input  logic         a_bit,
    input  logic         calc_vld,
    input  logic         b_bit,
    input  logic         k_bit,
    input  logic         sync,
    input  logic         dsp_en,
    output logic         ser_out,
    output logic         ser_vld,
    output logic [W-1:0] disp_q,
    output logic         blank_q
);
    localparam int CW = $clog2(W);
    localparam int UW = $clog2(W + 1);

    logic [CW-1:0] bcnt;
    logic [UW-1:0] ucnt;
    logic          busy, en_cap;
    logic          calc_step, load_step, first, last;
    logic          lsb, msb, r_bit, blank_pend;
    logic [W-1:0]  stage;

    assign busy      = (ucnt != '0);
    assign calc_step = calc_vld & ~busy;
    assign load_step = a_vld & ~busy & ~calc_vld;
    assign first     = (bcnt == '0);
    assign last      = (bcnt == CW'(W - 1));
    assign ser_out   = msb;
    assign ser_vld   = busy;

    sod_bit_alu u_alu (
        .clk(clk), .rst_n(rst_n), .step(calc_step), .first(first), .last(last),
        .a_bit(lsb), .b_bit(b_bit), .k_bit(k_bit),
        .r_bit(r_bit), .blank_pend(blank_pend)
    );

    sod_shift_reg #(.W(W)) u_sr (
        .clk(clk), .rst_n(rst_n), .load(load_step), .load_bit(a_bit),
        .calc(calc_step), .calc_bit(r_bit), .unload(busy),
        .lsb(lsb), .msb(msb)
    );

    // Count bit positions within a word, wrapping after the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bcnt <= '0;
        else if (calc_step)
            bcnt <= last ? '0 : bcnt + 1'b1;
    end

    // Run the unload window and capture display-enable at sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ucnt   <= '0;
            en_cap <= 1'b0;
        end else if (busy) begin
            ucnt <= ucnt - 1'b1;
        end else if (sync) begin
            ucnt   <= UW'(W);
            en_cap <= dsp_en;
        end
    end

    // Assemble the unloaded word and transfer it to the display latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage   <= '0;
            disp_q  <= '0;
            blank_q <= 1'b0;
        end else if (busy) begin
            stage <= {stage[W-2:0], msb};
            if (ucnt == UW'(1) && en_cap) begin
                disp_q  <= {stage[W-2:0], msb};
                blank_q <= blank_pend;
            end
        end
    end

    // R2: the bit counter restarts after the most significant position.
    a_r2_word_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (calc_step && last) |=> (bcnt == '0));
    // R6: an unload window opens with the full word count.
    a_r6_window_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_vld) |-> (ucnt == UW'(W)));
    // R7: the latch and blank flag hold outside an enabled final unload cycle.
    a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && ucnt == UW'(1) && en_cap) |=> $stable({disp_q, blank_q}));
endmodule

// File: tb/serial_offset_diff_test.sv
module serial_offset_diff_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         a_vld = 0, a_bit = 0, calc_vld = 0, b_bit = 0, k_bit = 0;
    logic         sync = 0, dsp_en = 0;
    logic         ser_out, ser_vld, blank_q;
    logic [W-1:0] disp_q;

    int checks = 0;
    int errors = 0;
    bit mon_on = 0;
    bit done   = 0;

    logic [W-1:0] exp_reg   = '0;
    logic         exp_pend  = 1'b0;
    logic [W-1:0] exp_disp  = '0;
    logic         exp_blank = 1'b0;

    serial_offset_diff #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .a_vld(a_vld), .a_bit(a_bit),
        .calc_vld(calc_vld), .b_bit(b_bit), .k_bit(k_bit),
        .sync(sync), .dsp_en(dsp_en), .ser_out(ser_out), .ser_vld(ser_vld),
        .disp_q(disp_q), .blank_q(blank_q)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    // Per-clock comparison of the display latch against the reference (R7).
    always @(posedge clk) begin
        #1;
        if (mon_on && !done) begin
            check(disp_q == exp_disp, "R7 disp_q", disp_q, exp_disp);
            check(blank_q == exp_blank, "R7 blank_q", blank_q, exp_blank);
        end
    end

    // Load A only (R1), then optionally process B and K (R2, R4, R5).
    task automatic load_a(input int a);
        for (int i = 0; i < W; i++) begin
            @(negedge clk);
            a_vld = 1; a_bit = a[i];
        end
        @(negedge clk);
        a_vld = 0;
        exp_reg = a[W-1:0];
    endtask

    task automatic run_word(input int a, input int b, input int k);
        int d;
        load_a(a);
        for (int i = 0; i < W; i++) begin
            if (i > 0) @(negedge clk);
            calc_vld = 1; b_bit = b[i]; k_bit = k[i];
        end
        @(negedge clk);
        calc_vld = 0;
        d = (b - a) & 255;
        exp_reg  = 8'((d + k) & 255);
        exp_pend = (b < a) || (d + k > 255);
    endtask

    // Unload MSB first and check serial data (R3, R6); update latch model (R7).
    task automatic do_sync(input bit en);
        logic [W-1:0] word;
        word = exp_reg;
        @(negedge clk);
        sync = 1; dsp_en = en;
        @(negedge clk);
        sync = 0; dsp_en = 0;
        for (int i = 0; i < W; i++) begin
            check(ser_vld == 1'b1, "R6 ser_vld high", ser_vld, 1);
            check(ser_out == word[W-1-i], "R6/R3 ser_out MSB first", ser_out, word[W-1-i]);
            if (i == W - 1 && en) begin
                exp_disp  = word;
                exp_blank = exp_pend;
            end
            @(negedge clk);
        end
        check(ser_vld == 1'b0, "R6 ser_vld end", ser_vld, 0);
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(disp_q == 0, "R8 reset disp_q", disp_q, 0);
        check(blank_q == 0, "R8 reset blank_q", blank_q, 0);
        check(ser_vld == 0, "R8 reset ser_vld", ser_vld, 0);
        rst_n = 1;
        mon_on = 1;

        run_word(10, 50, 20);  do_sync(1);   // R2 plain difference
        run_word(50, 10, 100); do_sync(1);   // R5 borrow case
        run_word(0, 200, 100); do_sync(1);   // R5 carry case
        run_word(255, 255, 0); do_sync(1);   // R4 clean word after blanked words
        run_word(3, 3, 255);   do_sync(1);   // R2 upper limit, no blank
        run_word(128, 127, 200); do_sync(0); // R7 disabled transfer keeps latch
        load_a(8'hA5);         do_sync(0);   // R3 non-display traffic, A read back
        run_word(0, 0, 0);     do_sync(1);   // R1 zero operands
        run_word(1, 0, 1);     do_sync(1);   // R5 borrow cancelled by offset still blanks

        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule